// File: doc/BRIEF.md
# Root Hub Port Status and Control Register

This block holds the status and control word of one downstream port of a USB host root hub. Software reads one 32-bit word that reports whether a device is connected and what state the port is in: enabled, suspended, over-current, in reset, powered, and whether a low-speed device is attached. Five sticky change flags in the upper half record each state change until software clears them.

Writes do not store data. Each of the low command bits starts an action, and that action differs from what the same bit reports on a read. For example, writing 1 to the connect-status position disables the port, and writing 1 to the low-speed position removes port power. The change flags are cleared by writing 1 to them.

The port side supplies sampled connect, low-speed and over-current levels, a timebase tick, and an optional reset-complete pulse. The block drives the port power enable and the bus-reset request. A bus reset lasts a programmable number of ticks. When it ends, the port is enabled.

Top module: `rh_port_status`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` reads all zeros, and both `port_power_en` and `port_reset_drive` are 0.
- R2: Read layout, one cycle after sampling the inputs: bit 0 is `dev_connect`, bit 3 is `port_overcurrent`, and bit 9 is `dev_low_speed` gated by `dev_connect`.
- R3: Bit 1 reads enable. Writing 1 to bit 1 sets enable only while bit 0 reads 1. Writing 1 to bit 0 clears enable. Clear wins if both bits are written in the same cycle.
- R4: A cycle with `dev_connect` low clears enable in the next cycle.
- R5: Bit 2 reads suspend. Writing 1 to bit 2 sets suspend only while enabled. Writing 1 to bit 3 clears suspend, and clear wins if both are written together. Suspend also drops whenever enable is 0.
- R6: Bit 8 reads power and drives `port_power_en`. Writing 1 to bit 8 sets power, and writing 1 to bit 9 clears it. Clear wins if both are written together.
- R7: Bit 4 reads reset-in-progress and drives `port_reset_drive`. Writing 1 to bit 4 starts a reset only while bit 0 reads 1, `dev_connect` is high and no reset is running.
- R8: A running reset ends on the `timer_tick` that brings the tick count to `cfg_reset_ticks` (a value of 0 counts as 1), on a `reset_done` pulse, or on a cycle with `dev_connect` low. When a reset ends, bit 20 is set, and enable is set if the device is still connected.
- R9: Bits 16, 17, 18 and 19 are set on any transition of connect, enable, suspend and over-current respectively, and stay set until cleared.
- R10: Writing 1 to any of bits 16–20 clears that flag. Writing 0 leaves it unchanged. A new event in the same cycle keeps the flag set.
- R11: All bit positions other than 0–4, 8, 9 and 16–20 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 32 | Command and flag-clear word |
| rd_data | output | 32 | Status word |
| dev_connect | input | 1 | Device present on the port |
| dev_low_speed | input | 1 | Attached device is low speed |
| port_overcurrent | input | 1 | Over-current level from the port |
| timer_tick | input | 1 | Timebase pulse that paces bus reset |
| reset_done | input | 1 | Pulse that ends a running bus reset early |
| cfg_reset_ticks | input | TICK_W | Bus reset length in ticks |
| port_power_en | output | 1 | Port power switch enable |
| port_reset_drive | output | 1 | Request to drive bus reset on the port |

## Verification
The directed cases target several corner cases:
- Set-enable while disconnected. A design that skipped the check would enable an empty port.
- Set and clear of enable written together, and the same for suspend. Wrong priority would leave the port active.
- A flag clear that lands in the same cycle as a new event. Losing that event would hide a state change from software.
- A reset cut short by disconnect. The design must not enable the port.
- A reset length of zero.
- Writes to unused bits.

Seeded random traffic then mixes connect toggling, ticks, early completion and arbitrary write words against a bench model, which catches wrong bit positions and any command that leaks into a neighbouring field.

// File: rtl/rhp_pkg.sv
// Package: bit positions of the port status word and the port state record.
// Assumes a 32-bit register word; positions are fixed because software decodes them.
package rhp_pkg;
    localparam int WORD_W   = 32;
    localparam int FLAG_N   = 5;

    // read meaning / write command positions
    localparam int B_CONN   = 0;   // rd connect     / wr disable
    localparam int B_ENA    = 1;   // rd enable      / wr enable
    localparam int B_SUSP   = 2;   // rd suspend     / wr suspend
    localparam int B_OVC    = 3;   // rd overcurrent / wr resume
    localparam int B_RST    = 4;   // rd in reset    / wr start reset
    localparam int B_PWR    = 8;   // rd power       / wr power on
    localparam int B_LOWSPD = 9;   // rd low speed   / wr power off
    localparam int B_FLAG0  = 16;  // first change flag

    // change flag order inside the flag group
    localparam int F_CONN = 0;
    localparam int F_ENA  = 1;
    localparam int F_SUSP = 2;
    localparam int F_OVC  = 3;
    localparam int F_RST  = 4;

    typedef struct packed {
        logic conn;
        logic ena;
        logic susp;
        logic ovc;
        logic rst;
        logic pwr;
        logic lowspd;
    } port_state_t;
endpackage

// File: rtl/rhp_reset_timer.sv
// Module: counts timebase ticks while a bus reset runs and flags the ending tick.
// Assumes start and active are never high together; a limit of 0 acts as 1.
module rhp_reset_timer #(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              active,
    input  logic              tick,
    input  logic [TICK_W-1:0] limit,
    output logic              expire
);
    localparam int CNT_W = TICK_W + 1;

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] limit_eff;
    logic [CNT_W-1:0] count_inc;

    // effective limit and the count after this tick
    always_comb begin
        limit_eff = (limit == '0) ? CNT_W'(1) : {1'b0, limit};
        count_inc = count + CNT_W'(1);
        expire    = active && tick && (count_inc >= limit_eff);
    end

    // tick counter, cleared at reset start
    always_ff @(posedge clk) begin
        if (!rst_n || start)
            count <= '0;
        else if (active && tick && !expire)
            count <= count_inc;
    end
endmodule

// File: rtl/rhp_change_flags.sv
// Module: sticky change flags; an event sets a flag, a one written clears it.
// Assumes an event in the same cycle as a clear keeps the flag set.
module rhp_change_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] event_in,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // one sticky bit per tracked state
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (event_in[i])
                flags[i] <= 1'b1;
            else if (clr[i])
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/rhp_link_state.sv
// Module: port state bits and their change events, driven by write commands
// and port inputs. Assumes inputs are already synchronous to clk.
module rhp_link_state
    import rhp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic        dev_connect,
    input  logic        dev_low_speed,
    input  logic        port_overcurrent,
    input  logic        timer_expire,
    input  logic        reset_done,
    output logic        reset_start,
    output port_state_t st,
    output logic [FLAG_N-1:0] events
);
    port_state_t nx;
    logic cmd_dis, cmd_ena, cmd_susp, cmd_resume, cmd_reset, cmd_pon, cmd_poff;
    logic reset_end;

    // decode write commands
    always_comb begin
        cmd_dis    = wr_en && wr_data[B_CONN];
        cmd_ena    = wr_en && wr_data[B_ENA];
        cmd_susp   = wr_en && wr_data[B_SUSP];
        cmd_resume = wr_en && wr_data[B_OVC];
        cmd_reset  = wr_en && wr_data[B_RST];
        cmd_pon    = wr_en && wr_data[B_PWR];
        cmd_poff   = wr_en && wr_data[B_LOWSPD];
    end

    // next-state evaluation with command priorities
    always_comb begin
        reset_end   = st.rst && (!dev_connect || reset_done || timer_expire);
        reset_start = cmd_reset && st.conn && dev_connect && !st.rst;

        nx.conn   = dev_connect;
        nx.ovc    = port_overcurrent;
        nx.lowspd = dev_low_speed && dev_connect;

        if (!dev_connect)             nx.ena = 1'b0;
        else if (reset_end)           nx.ena = 1'b1;
        else if (cmd_dis)             nx.ena = 1'b0;
        else if (cmd_ena && st.conn)  nx.ena = 1'b1;
        else                          nx.ena = st.ena;

        if (!nx.ena)                  nx.susp = 1'b0;
        else if (cmd_resume)          nx.susp = 1'b0;
        else if (cmd_susp && st.ena)  nx.susp = 1'b1;
        else                          nx.susp = st.susp;

        if (st.rst)                   nx.rst = !reset_end;
        else                          nx.rst = reset_start;

        if (cmd_poff)                 nx.pwr = 1'b0;
        else if (cmd_pon)             nx.pwr = 1'b1;
        else                          nx.pwr = st.pwr;
    end

    // change events: any transition, or the end of a reset
    always_comb begin
        events         = '0;
        events[F_CONN] = nx.conn != st.conn;
        events[F_ENA]  = nx.ena  != st.ena;
        events[F_SUSP] = nx.susp != st.susp;
        events[F_OVC]  = nx.ovc  != st.ovc;
        events[F_RST]  = reset_end;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= '0;
        else
            st <= nx;
    end
endmodule

// File: rtl/rh_port_status.sv
// Module: root hub port status/control register top. Assembles the status word
// from the state bits and change flags and drives the port power and reset.
// Assumes one port, a 32-bit word and synchronous port inputs.
module rh_port_status
    import rhp_pkg::*;
#(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic              dev_connect,
    input  logic              dev_low_speed,
    input  logic              port_overcurrent,
    input  logic              timer_tick,
    input  logic              reset_done,
    input  logic [TICK_W-1:0] cfg_reset_ticks,
    output logic              port_power_en,
    output logic              port_reset_drive
);
    port_state_t       st;
    logic [FLAG_N-1:0] events;
    logic [FLAG_N-1:0] flags;
    logic [FLAG_N-1:0] flag_clr;
    logic              reset_start;
    logic              timer_expire;

    rhp_link_state u_state (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_en            (wr_en),
        .wr_data          (wr_data),
        .dev_connect      (dev_connect),
        .dev_low_speed    (dev_low_speed),
        .port_overcurrent (port_overcurrent),
        .timer_expire     (timer_expire),
        .reset_done       (reset_done),
        .reset_start      (reset_start),
        .st               (st),
        .events           (events)
    );

    rhp_reset_timer #(.TICK_W(TICK_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (reset_start),
        .active (st.rst),
        .tick   (timer_tick),
        .limit  (cfg_reset_ticks),
        .expire (timer_expire)
    );

    // write-one-to-clear strobes for the flag group
    always_comb begin
        flag_clr = wr_en ? wr_data[B_FLAG0 +: FLAG_N] : '0;
    end

    rhp_change_flags #(.N(FLAG_N)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_in (events),
        .clr      (flag_clr),
        .flags    (flags)
    );

    // status word assembly
    always_comb begin
        rd_data                       = '0;
        rd_data[B_CONN]               = st.conn;
        rd_data[B_ENA]                = st.ena;
        rd_data[B_SUSP]               = st.susp;
        rd_data[B_OVC]                = st.ovc;
        rd_data[B_RST]                = st.rst;
        rd_data[B_PWR]                = st.pwr;
        rd_data[B_LOWSPD]             = st.lowspd;
        rd_data[B_FLAG0 +: FLAG_N]    = flags;
        port_power_en                 = st.pwr;
        port_reset_drive              = st.rst;
    end
endmodule

// File: rtl/rh_port_status_chk.sv
// Module: assertion checker for rh_port_status, attached by bind.
module rh_port_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        dev_connect,
    input logic        port_power_en,
    input logic        port_reset_drive
);
    // R1: a reset cycle leaves the word clear
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (rd_data == 32'h0 && !port_power_en && !port_reset_drive));

    // R4: disconnect removes enable
    a_r4_disc_disables: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_connect |=> !rd_data[1]);

    // R5: suspend only while enabled
    a_r5_susp_needs_ena: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[2] |-> rd_data[1]);

    // R6: power-off command wins
    a_r6_power_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[9]) |=> !port_power_en);

    // R7: reset starts only by command on a connected port
    a_r7_reset_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_reset_drive) |-> $past(wr_en && wr_data[4] && rd_data[0]));

    // R8: end of reset raises its change flag
    a_r8_reset_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(port_reset_drive) |-> rd_data[20]);

    // R9: a new connection raises the connect change flag
    a_r9_conn_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[0]) |-> rd_data[16]);

    // R11: unused positions always read zero
    a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~32'h001F_031F) == 32'h0);
endmodule

bind rh_port_status rh_port_status_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_en            (wr_en),
    .wr_data          (wr_data),
    .rd_data          (rd_data),
    .dev_connect      (dev_connect),
    .port_power_en    (port_power_en),
    .port_reset_drive (port_reset_drive)
);

// File: tb/rh_port_status_bench.sv
// Bench: directed corner cases then seeded random traffic, all compared
// against a cycle model written from the requirements.
module rh_port_status_bench;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic          dev_connect = 1'b0;
    logic          dev_low_speed = 1'b0;
    logic          port_overcurrent = 1'b0;
    logic          timer_tick = 1'b0;
    logic          reset_done = 1'b0;
    logic [TW-1:0] cfg_reset_ticks = 8'd3;
    logic          port_power_en;
    logic          port_reset_drive;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // model state
    bit m_conn, m_ena, m_susp, m_ovc, m_rst, m_pwr, m_ls;
    bit [4:0] m_flags;
    int m_cnt;

    rh_port_status #(.TICK_W(TW)) u_rh_port_status (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_en            (wr_en),
        .wr_data          (wr_data),
        .rd_data          (rd_data),
        .dev_connect      (dev_connect),
        .dev_low_speed    (dev_low_speed),
        .port_overcurrent (port_overcurrent),
        .timer_tick       (timer_tick),
        .reset_done       (reset_done),
        .cfg_reset_ticks  (cfg_reset_ticks),
        .port_power_en    (port_power_en),
        .port_reset_drive (port_reset_drive)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] expected_word();
        logic [31:0] w = '0;
        w[0] = m_conn; w[1] = m_ena; w[2] = m_susp; w[3] = m_ovc;
        w[4] = m_rst;  w[8] = m_pwr; w[9] = m_ls;
        w[20:16] = m_flags;
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // advance the model by one clock from the current inputs
    task automatic model_step();
        bit w = wr_en;
        bit r_end, r_start, n_ena, n_susp, n_rst, n_pwr;
        bit [4:0] ev;
        int lim = (cfg_reset_ticks == 0) ? 1 : int'(cfg_reset_ticks);
        bit t_exp = m_rst && timer_tick && (m_cnt + 1 >= lim);
        r_end   = m_rst && (!dev_connect || reset_done || t_exp);
        r_start = w && wr_data[4] && m_conn && dev_connect && !m_rst;
        if (!dev_connect) n_ena = 0;
        else if (r_end) n_ena = 1;
        else if (w && wr_data[0]) n_ena = 0;
        else if (w && wr_data[1] && m_conn) n_ena = 1;
        else n_ena = m_ena;
        if (!n_ena) n_susp = 0;
        else if (w && wr_data[3]) n_susp = 0;
        else if (w && wr_data[2] && m_ena) n_susp = 1;
        else n_susp = m_susp;
        n_rst = m_rst ? !r_end : r_start;
        if (w && wr_data[9]) n_pwr = 0;
        else if (w && wr_data[8]) n_pwr = 1;
        else n_pwr = m_pwr;
        ev = {r_end, bit'(port_overcurrent != m_ovc), bit'(n_susp != m_susp),
              bit'(n_ena != m_ena), bit'(dev_connect != m_conn)};
        m_flags = ev | (m_flags & ~(w ? wr_data[20:16] : 5'b0));
        if (r_start) m_cnt = 0;
        else if (m_rst && timer_tick && !t_exp) m_cnt = m_cnt + 1;
        m_conn = dev_connect; m_ovc = port_overcurrent;
        m_ls = dev_low_speed && dev_connect;
        m_ena = n_ena; m_susp = n_susp; m_rst = n_rst; m_pwr = n_pwr;
    endtask

    // one clock with given inputs, then compare the whole word
    task automatic cyc(input string tag, input bit we, input logic [31:0] wd,
                       input bit tk = 0, input bit dn = 0);
        wr_en = we; wr_data = wd; timer_tick = tk; reset_done = dn;
        model_step();
        @(posedge clk); #1;
        check(tag, rd_data, expected_word());
        check(tag, {30'b0, port_power_en, port_reset_drive}, {30'b0, m_pwr, m_rst});
        wr_en = 0; wr_data = '0; timer_tick = 0; reset_done = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24680));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        check("R1", rd_data, 32'h0);
        check("R1", {30'b0, port_power_en, port_reset_drive}, 32'h0);

        cyc("R6 power on", 1, 32'h0000_0100);
        cyc("R6 on+off together", 1, 32'h0000_0300);
        check("R6", {31'b0, port_power_en}, 32'h0);
        cyc("R6 power on again", 1, 32'h0000_0100);
        cyc("R3 enable ignored while disconnected", 1, 32'h0000_0002);
        check("R3", {31'b0, rd_data[1]}, 32'h0);

        dev_connect = 1; dev_low_speed = 1;
        cyc("R2 connect", 0, 0);
        check("R2", rd_data & 32'h209, 32'h201);
        check("R9 connect flag", {31'b0, rd_data[16]}, 32'h1);
        cyc("R10 clear connect flag", 1, 32'h0001_0000);
        check("R10", {31'b0, rd_data[16]}, 32'h0);
        cyc("R11 unused bits", 1, 32'hFFE0_FCE0);
        check("R11", rd_data, 32'h0000_0301);

        cyc("R3 set+clear enable", 1, 32'h0000_0003);
        check("R3", {31'b0, rd_data[1]}, 32'h0);
        cyc("R3 set enable", 1, 32'h0000_0002);
        check("R3", {31'b0, rd_data[1]}, 32'h1);
        check("R9 enable flag", {31'b0, rd_data[17]}, 32'h1);
        cyc("R5 suspend+resume together", 1, 32'h0000_000C);
        check("R5", {31'b0, rd_data[2]}, 32'h0);
        cyc("R5 suspend", 1, 32'h0000_0004);
        check("R5", {31'b0, rd_data[2]}, 32'h1);
        cyc("R5 resume", 1, 32'h0000_0008);
        check("R5", {31'b0, rd_data[2]}, 32'h0);

        port_overcurrent = 1;
        cyc("R10 clear during new event", 1, 32'h0008_0000);
        check("R9 overcurrent flag kept", rd_data & 32'h0008_0008, 32'h0008_0008);
        port_overcurrent = 0;
        cyc("R2 overcurrent drop", 0, 0);

        cyc("R7 start reset", 1, 32'h0001_0010);
        check("R7", {31'b0, port_reset_drive}, 32'h1);
        cyc("R8 tick 1", 0, 0, 1);
        cyc("R8 idle", 0, 0);
        cyc("R8 tick 2", 0, 0, 1);
        check("R8 still resetting", {31'b0, rd_data[4]}, 32'h1);
        cyc("R8 tick 3 ends", 0, 0, 1);
        check("R8 reset ended", rd_data & 32'h0010_0012, 32'h0010_0002);

        cfg_reset_ticks = 0;
        cyc("R7 second reset", 1, 32'h0010_0010);
        cyc("R8 zero length ends on first tick", 0, 0, 1);
        check("R8", {31'b0, rd_data[4]}, 32'h0);

        cyc("R3 disable", 1, 32'h0000_0001);
        cyc("R7 reset again", 1, 32'h0000_0010);
        dev_connect = 0;
        cyc("R8 abort by disconnect", 0, 0);
        check("R4 no enable after abort", rd_data & 32'h0000_0013, 32'h0);
        cyc("R7 no reset while disconnected", 1, 32'h0000_0010);
        check("R7", {31'b0, port_reset_drive}, 32'h0);

        cfg_reset_ticks = 8'd2;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 12 == 0) dev_connect = ~dev_connect;
            if ($urandom % 20 == 0) dev_low_speed = ~dev_low_speed;
            if ($urandom % 30 == 0) port_overcurrent = ~port_overcurrent;
            if (i == 2000) cfg_reset_ticks = 8'd5;
            cyc("random R2 R3 R5 R8 R9 R10", ($urandom % 3 == 0),
                $urandom, ($urandom % 3 == 0), ($urandom % 40 == 0));
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule